// File: doc/BRIEF.md
# Nonvolatile Array Unlock and Program Sequencer

This block is the control front end for a small on-chip nonvolatile memory array. The array is modelled here as a register file within the design. Software reaches the block through a narrow register port with four selectable registers: key, control, address and status. Memory programming goes through a separate half-word write port, and a combinational port reads the array back.

After reset the control register is locked. Software must write two fixed key words to the key register, in the correct order and with no other key write between them. Once unlocked, software can erase one page, which sets every half-word in it to 0xFFFF. It can also program one 16-bit half-word. Each operation holds a busy flag for a parameterised number of cycles. At the end of the operation the result is committed, or an error is recorded instead. Two conditions are reported: an attempt to overwrite data that has not been erased, and any access to a page marked as protected by the per-page protection input. Any key write that breaks the sequence disables the key register until the next reset.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset `lock_o`=1, `busy_o`=0 and both error flags are 0. Writing 0x45670123 to the key register (select 0), followed by 0xCDEF89AB as the next key-register write, clears `lock_o`.
- R2: If a key write has a wrong value, or the two keys arrive in the wrong order, the block stays locked and ignores every later key write until reset. A fresh reset allows unlocking again.
- R3: A control write (select 1) with bit 7 set relocks the block. `lock_o` reads 1 and the PG and PER bits clear. The two-key sequence then unlocks the block again.
- R4: While the block is locked or `busy_o`=1, writes to the control and address registers (select 2) are ignored. Control bit 0 is PG and bit 1 is PER.
- R5: A control write with bit 1 (PER) and bit 6 (start) both set begins an erase. The target is the page that contains the half-word index held in the address register. `busy_o` is high for exactly ERASE_CYC cycles. When it falls, every half-word of that page reads 0xFFFF.
- R6: When PG=1 and the block is idle, a `mem_we` pulse programs `mem_wdata` at `mem_addr`. `busy_o` is high for exactly PROG_CYC cycles, and the new value is readable when it falls.
- R7: Programming a half-word that is not 0xFFFF with any value other than 0x0000 sets PGERR and leaves the contents unchanged. Writing 0x0000 over existing data is allowed.
- R8: A program or erase that targets a page whose `wp_mask` bit is 1 sets WPERR and leaves memory unchanged.
- R9: The error flags are sticky. Writing 1 to bit 2 (PGERR) or bit 4 (WPERR) of the status register (select 3) clears that flag. Writing 0 has no effect.
- R10: A `mem_we` pulse while PG=0 or while `busy_o`=1 is ignored: no operation starts and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 key, 1 control, 2 address, 3 status |
| cfg_wdata | input | 32 | Register write data |
| mem_we | input | 1 | Half-word program request |
| mem_addr | input | AW | Half-word index to program |
| mem_wdata | input | 16 | Half-word to program |
| wp_mask | input | NUM_PAGES | Per-page protection, 1 = protected |
| rd_addr | input | AW | Read half-word index |
| rd_data | output | 16 | Array contents at rd_addr |
| lock_o | output | 1 | Control register locked |
| pg_o | output | 1 | Program mode bit |
| per_o | output | 1 | Page-erase mode bit |
| busy_o | output | 1 | Operation in progress |
| pgerr_o | output | 1 | Sticky programming error |
| wperr_o | output | 1 | Sticky protection error |

## Verification
Register writes take effect at the clock edge that samples them. Lock and mode bits change one cycle after the strobe, and `busy_o` rises one cycle after a start. `busy_o` stays high for exactly PROG_CYC or ERASE_CYC cycles. Memory contents and error flags change on the same edge where `busy_o` falls. The bench drives and samples on falling edges. It checks `busy_o` high right after the start and again after PROG_CYC-1 or ERASE_CYC-1 further cycles, then one cycle later checks that `busy_o` is low, together with the committed data and the flags.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  typedef enum logic [1:0] {KS_WAIT_K1, KS_WAIT_K2, KS_OPEN, KS_DEAD} key_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;

  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam logic [1:0] SEL_KEY  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CB_PG   = 0;
  localparam int CB_PER  = 1;
  localparam int CB_STRT = 6;
  localparam int CB_LOCK = 7;
  localparam int SB_PGERR = 2;
  localparam int SB_WPERR = 4;
endpackage

// File: rtl/nvm_key_fsm.sv
`timescale 1ns/1ps
module nvm_key_fsm
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        unlocked
);
  key_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      KS_WAIT_K1: if (key_we) state_n = (key_val == KEY_FIRST)  ? KS_WAIT_K2 : KS_DEAD;
      KS_WAIT_K2: if (key_we) state_n = (key_val == KEY_SECOND) ? KS_OPEN    : KS_DEAD;
      KS_OPEN:    if (relock) state_n = KS_WAIT_K1;
      default:    state_n = KS_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_WAIT_K1;
    else        state_q <= state_n;
  end

  assign unlocked = (state_q == KS_OPEN);

  // R2: once the sequence is broken only reset leaves the dead state
  a_r2_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == KS_DEAD |=> state_q == KS_DEAD);
  // R1: opening always follows a correct second key
  a_r1_open_after_key2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_we && key_val == KEY_SECOND));
endmodule

// File: rtl/nvm_busy_timer.sv
`timescale 1ns/1ps
module nvm_busy_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 32,
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy;
    done   = 1'b0;
    if (busy) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end else if (start_prog) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(PROG_CYC - 1);
    end else if (start_erase) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(ERASE_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_n;
      cnt_q <= cnt_n;
    end
  end

  // R6: completion ends the busy window on the next cycle
  a_r6_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5: a start while idle always raises busy
  a_r5_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_prog || start_erase)) |=> busy);
endmodule

// File: rtl/nvm_array.sv
`timescale 1ns/1ps
module nvm_array
  import nvm_pkg::*;
#(
  parameter int HW_PER_PAGE = 8,
  parameter int NUM_PAGES   = 4,
  localparam int DEPTH  = HW_PER_PAGE * NUM_PAGES,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = $clog2(HW_PER_PAGE),
  localparam int PAGE_W = AW - PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  op_e                  op,
  input  logic [AW-1:0]        op_addr,
  input  logic [15:0]          op_data,
  input  logic [NUM_PAGES-1:0] wp_mask,
  input  logic [AW-1:0]        rd_addr,
  output logic [15:0]          rd_data,
  output logic                 set_pgerr,
  output logic                 set_wperr
);
  logic [15:0]          mem [DEPTH];
  logic [NUM_PAGES-1:0] page_sel;
  logic                 wp_hit, blank, do_prog, do_erase;
  logic [15:0]          cur;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign page_sel[p] = (op_addr[AW-1:PW] == PAGE_W'(p));
  end

  assign wp_hit    = |(page_sel & wp_mask);
  assign cur       = mem[op_addr];
  assign blank     = (cur == 16'hFFFF);
  assign set_wperr = done && (op != OP_NONE) && wp_hit;
  assign set_pgerr = done && (op == OP_PROG) && !wp_hit && !blank && (op_data != 16'h0000);
  assign do_prog   = done && (op == OP_PROG) && !wp_hit && !set_pgerr;
  assign do_erase  = done && (op == OP_ERASE) && !wp_hit;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_erase && page_sel[i / HW_PER_PAGE])
        mem[i] <= 16'hFFFF;
      else if (do_prog && op_addr == AW'(i))
        mem[i] <= op_data;
    end
  end

  // R8: a protected program leaves the target word untouched
  a_r8_wp_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PROG && wp_hit) |=> mem[$past(op_addr)] == $past(cur));
  // R7: a rejected overwrite leaves the target word untouched
  a_r7_pgerr_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    set_pgerr |=> mem[$past(op_addr)] == $past(cur));
endmodule

// File: rtl/nvm_prog_ctrl.sv
`timescale 1ns/1ps
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int HW_PER_PAGE = 8,
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 32,
  localparam int AW = $clog2(HW_PER_PAGE * NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [31:0]          cfg_wdata,
  input  logic                 mem_we,
  input  logic [AW-1:0]        mem_addr,
  input  logic [15:0]          mem_wdata,
  input  logic [NUM_PAGES-1:0] wp_mask,
  input  logic [AW-1:0]        rd_addr,
  output logic [15:0]          rd_data,
  output logic                 lock_o,
  output logic                 pg_o,
  output logic                 per_o,
  output logic                 busy_o,
  output logic                 pgerr_o,
  output logic                 wperr_o
);
  logic          unlocked, cfg_ok, ctrl_wr, relock, start_prog, start_erase, done;
  logic          set_pgerr, set_wperr;
  logic          pg_n, per_n, pgerr_n, wperr_n;
  logic [AW-1:0] addr_q, addr_n, op_addr_q, op_addr_n;
  logic [15:0]   op_data_q, op_data_n;
  op_e           op_q, op_n;

  assign cfg_ok      = cfg_we && unlocked && !busy_o;
  assign ctrl_wr     = cfg_ok && (cfg_sel == SEL_CTRL);
  assign relock      = ctrl_wr && cfg_wdata[CB_LOCK];
  assign start_prog  = mem_we && pg_o && !busy_o;
  assign start_erase = ctrl_wr && !cfg_wdata[CB_LOCK] && cfg_wdata[CB_STRT] && cfg_wdata[CB_PER];
  assign lock_o      = !unlocked;

  nvm_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (cfg_we && cfg_sel == SEL_KEY),
    .key_val  (cfg_wdata),
    .relock   (relock),
    .unlocked (unlocked)
  );

  nvm_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .busy        (busy_o),
    .done        (done)
  );

  nvm_array #(.HW_PER_PAGE(HW_PER_PAGE), .NUM_PAGES(NUM_PAGES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .op        (op_q),
    .op_addr   (op_addr_q),
    .op_data   (op_data_q),
    .wp_mask   (wp_mask),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .set_pgerr (set_pgerr),
    .set_wperr (set_wperr)
  );

  always_comb begin
    pg_n      = pg_o;
    per_n     = per_o;
    addr_n    = addr_q;
    op_n      = op_q;
    op_addr_n = op_addr_q;
    op_data_n = op_data_q;
    pgerr_n   = pgerr_o;
    wperr_n   = wperr_o;
    if (relock) begin
      pg_n  = 1'b0;
      per_n = 1'b0;
    end else if (ctrl_wr) begin
      pg_n  = cfg_wdata[CB_PG];
      per_n = cfg_wdata[CB_PER];
    end
    if (cfg_ok && cfg_sel == SEL_ADDR) addr_n = cfg_wdata[AW-1:0];
    if (start_prog) begin
      op_n      = OP_PROG;
      op_addr_n = mem_addr;
      op_data_n = mem_wdata;
    end else if (start_erase) begin
      op_n      = OP_ERASE;
      op_addr_n = addr_q;
    end else if (done) begin
      op_n = OP_NONE;
    end
    if (cfg_we && cfg_sel == SEL_STAT && cfg_wdata[SB_PGERR]) pgerr_n = 1'b0;
    if (cfg_we && cfg_sel == SEL_STAT && cfg_wdata[SB_WPERR]) wperr_n = 1'b0;
    if (set_pgerr) pgerr_n = 1'b1;
    if (set_wperr) wperr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_o      <= 1'b0;
      per_o     <= 1'b0;
      addr_q    <= '0;
      op_q      <= OP_NONE;
      op_addr_q <= '0;
      op_data_q <= '0;
      pgerr_o   <= 1'b0;
      wperr_o   <= 1'b0;
    end else begin
      pg_o      <= pg_n;
      per_o     <= per_n;
      addr_q    <= addr_n;
      op_q      <= op_n;
      op_addr_q <= op_addr_n;
      op_data_q <= op_data_n;
      pgerr_o   <= pgerr_n;
      wperr_o   <= wperr_n;
    end
  end

  // R4: a locked control register cannot raise a mode bit
  a_r4_locked_modes_low: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> !pg_o && !per_o);
  // R4: control writes during busy leave the mode bits alone
  a_r4_busy_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(pg_o) && $stable(per_o));
  // R9: error flags fall only through a status write of 1
  a_r9_pgerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pgerr_o && !(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[SB_PGERR])) |=> pgerr_o);
  a_r9_wperr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wperr_o && !(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[SB_WPERR])) |=> wperr_o);
  // R10: a memory write without PG starts nothing
  a_r10_no_pg_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !pg_o && !busy_o && !cfg_we) |=> !busy_o);
endmodule

// File: tb/nvm_prog_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_bench;
  localparam int HPP = 8, NP = 4, PCYC = 8, ECYC = 32, AW = 5;

  logic          clk, rst_n, cfg_we, mem_we;
  logic [1:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic [AW-1:0] mem_addr, rd_addr;
  logic [15:0]   mem_wdata, rd_data;
  logic [NP-1:0] wp_mask;
  logic          lock_o, pg_o, per_o, busy_o, pgerr_o, wperr_o;
  int            checks, errors;
  logic [15:0]   saved;

  nvm_prog_ctrl #(.HW_PER_PAGE(HPP), .NUM_PAGES(NP), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u_nvm_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wp_mask(wp_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .lock_o(lock_o), .pg_o(pg_o), .per_o(per_o),
    .busy_o(busy_o), .pgerr_o(pgerr_o), .wperr_o(wperr_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    rd_addr = a; #0.5;
    chk_eq(req, {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic busy_window(input string req, input int cyc);
    chk_eq(req, busy_o, 1'b1);
    repeat (cyc - 1) @(negedge clk);
    chk_eq(req, busy_o, 1'b1);
    @(negedge clk);
    chk_eq(req, busy_o, 1'b0);
  endtask

  task automatic do_reset();
    cfg_we = 0; mem_we = 0; cfg_sel = 0; cfg_wdata = 0; mem_addr = 0; mem_wdata = 0; rd_addr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    reg_wr(2'd0, 32'h4567_0123);
    reg_wr(2'd0, 32'hCDEF_89AB);
  endtask

  task automatic t_reset_and_unlock();
    do_reset();
    chk_eq("R1 reset lock", lock_o, 1'b1);
    chk_eq("R1 reset busy", busy_o, 1'b0);
    chk_eq("R1 reset errs", {pgerr_o, wperr_o}, 2'b00);
    reg_wr(2'd1, 32'h1);
    chk_eq("R4 locked ctrl write ignored", pg_o, 1'b0);
    reg_wr(2'd0, 32'h4567_0123);
    chk_eq("R1 still locked after first key", lock_o, 1'b1);
    reg_wr(2'd0, 32'hCDEF_89AB);
    chk_eq("R1 unlocked", lock_o, 1'b0);
  endtask

  task automatic t_erase();
    for (int p = 0; p < 3; p++) begin
      reg_wr(2'd1, 32'h2);
      reg_wr(2'd2, p * HPP + 3);
      reg_wr(2'd1, 32'h42);
      busy_window("R5 erase busy length", ECYC);
    end
    rd_chk("R5 erased first word", 5'd8, 16'hFFFF);
    rd_chk("R5 erased last word", 5'd15, 16'hFFFF);
    rd_chk("R5 erased page0", 5'd0, 16'hFFFF);
  endtask

  task automatic t_program();
    reg_wr(2'd1, 32'h1);
    chk_eq("R6 pg set", pg_o, 1'b1);
    mem_wr(5'd9, 16'h1234);
    busy_window("R6 program busy length", PCYC);
    rd_chk("R6 programmed", 5'd9, 16'h1234);
    rd_chk("R6 neighbour untouched", 5'd10, 16'hFFFF);
    chk_eq("R6 no error", {pgerr_o, wperr_o}, 2'b00);
  endtask

  task automatic t_overwrite();
    mem_wr(5'd9, 16'h5555);
    busy_window("R7 overwrite busy", PCYC);
    chk_eq("R7 pgerr set", pgerr_o, 1'b1);
    rd_chk("R7 contents kept", 5'd9, 16'h1234);
    mem_wr(5'd9, 16'h0000);
    busy_window("R7 zero busy", PCYC);
    rd_chk("R7 zero over data allowed", 5'd9, 16'h0000);
    chk_eq("R9 pgerr sticky", pgerr_o, 1'b1);
    reg_wr(2'd3, 32'h0);
    chk_eq("R9 write 0 no effect", pgerr_o, 1'b1);
    reg_wr(2'd3, 32'h4);
    chk_eq("R9 pgerr cleared", pgerr_o, 1'b0);
  endtask

  task automatic t_protect();
    rd_addr = 5'd26; #0.5; saved = rd_data;
    mem_wr(5'd26, 16'h0000);
    busy_window("R8 protected program busy", PCYC);
    chk_eq("R8 wperr on program", wperr_o, 1'b1);
    rd_chk("R8 protected word kept", 5'd26, saved);
    reg_wr(2'd3, 32'h10);
    chk_eq("R9 wperr cleared", wperr_o, 1'b0);
    reg_wr(2'd1, 32'h2);
    reg_wr(2'd2, 32'd26);
    reg_wr(2'd1, 32'h42);
    busy_window("R8 protected erase busy", ECYC);
    chk_eq("R8 wperr on erase", wperr_o, 1'b1);
    rd_chk("R8 protected page kept", 5'd26, saved);
    reg_wr(2'd3, 32'h10);
  endtask

  task automatic t_busy_ignore();
    reg_wr(2'd1, 32'h1);
    mem_wr(5'd1, 16'hA5A5);
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd2, 32'd17);
    mem_wr(5'd2, 16'h0F0F);
    repeat (PCYC) @(negedge clk);
    chk_eq("R4 busy ctrl write ignored", pg_o, 1'b1);
    rd_chk("R10 busy mem write ignored", 5'd2, 16'hFFFF);
    rd_chk("R6 first write landed", 5'd1, 16'hA5A5);
    reg_wr(2'd1, 32'h0);
    mem_wr(5'd3, 16'h1111);
    chk_eq("R10 no busy without pg", busy_o, 1'b0);
    @(negedge clk);
    rd_chk("R10 pg clear ignored", 5'd3, 16'hFFFF);
  endtask

  task automatic t_relock();
    reg_wr(2'd1, 32'h1);
    reg_wr(2'd1, 32'h80);
    chk_eq("R3 relocked", lock_o, 1'b1);
    chk_eq("R3 pg cleared", pg_o, 1'b0);
    reg_wr(2'd1, 32'h1);
    chk_eq("R4 ctrl ignored after relock", pg_o, 1'b0);
    unlock();
    chk_eq("R3 unlock again", lock_o, 1'b0);
  endtask

  task automatic t_bad_keys();
    reg_wr(2'd1, 32'h80);
    reg_wr(2'd0, 32'hCDEF_89AB);
    unlock();
    chk_eq("R2 wrong order keeps lock", lock_o, 1'b1);
    unlock();
    chk_eq("R2 later keys ignored", lock_o, 1'b1);
    do_reset();
    reg_wr(2'd0, 32'h4567_0124);
    unlock();
    chk_eq("R2 wrong value keeps lock", lock_o, 1'b1);
    do_reset();
    unlock();
    chk_eq("R2 reset restores unlock", lock_o, 1'b0);
  endtask

  initial begin
    checks = 0; errors = 0;
    wp_mask = 4'b1000;
    t_reset_and_unlock();
    t_erase();
    t_program();
    t_overwrite();
    t_protect();
    t_busy_ignore();
    t_relock();
    t_bad_keys();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule